// File: doc/BRIEF.md
# Odd-Number Step Unit for the 3/5/9 Multiply-Add Map

This unit performs one step of the map that takes an odd integer n, forms x·n + 1 for x of 3, 5 or 9, and divides out every factor of two so that the result is odd again. The unit has no multiplier. Because x = 1 + 2^k, the product is the sum of n and n shifted left by k, and a carry-in of one supplies the +1. The sum is built from 64-bit prefix-tree word adders. The carry out of each word feeds the next word in turn. A trailing-zero count and a right barrel shift then give the odd result and the divisor exponent d.

The adder is also a measuring instrument. For every bit position of the two addends, the unit classifies the pair as generate, propagate or kill. It reports the three population counts and the longest run of positions that a single carry crosses. A statistics enable turns this reporting off without touching the arithmetic. Inputs that are even, and select codes that name no multiplier, are rejected with an error flag. A sum that does not fit the operand width raises an overflow flag instead of giving a result.

Inputs arrive on a valid/ready handshake. Each accepted input produces exactly one output beat on a second valid/ready handshake. The output beat appears one cycle after acceptance.

Top module: `collatz_step`

## Requirements
- R1: For an odd n and select code 1, 2 or 3 (x = 3, 5, 9), with no overflow, outN is (x·n + 1) / 2^d. Here d is the number of trailing zeros of x·n + 1, so outN is odd, and outShift is d.
- R2: With statistics on, outGen, outProp and outKill count the 128 bit positions of the addends n and (n << code), truncated to 128 bits. A position is generate if both bits are 1, propagate if exactly one bit is 1, and kill if both bits are 0. The three counts sum to 128.
- R3: With statistics on, outChain is the longest run of consecutive positions crossed by one carry. A run starts at a generate position, or at bit 0 fed by the carry-in when bit 0 propagates. Each following propagate position that receives the carry adds one to the run.
- R4: With statEn low, outGen, outProp, outKill and outChain are zero. outN, outShift and outOverflow are the same as with statEn high.
- R5: When x·n + 1 is 2^128 or more, outOverflow is 1 and outN and outShift are 0. The statistics are still reported as in R2 to R4.
- R6: An even n, or select code 0, gives outError = 1 with outOverflow, outN, outShift and all statistics at 0.
- R7: inReady is high whenever outValid is low or outReady is high. An input accepted on a clock edge appears with outValid high after that edge. While outValid is high and outReady is low, the output beat is held unchanged.
- R8: A carry leaving bit 63 of the low word enters bit 64 of the high word, so sums that cross the word boundary are exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat offered |
| inReady | output | 1 | Input beat can be taken |
| inN | input | 128 | Operand n |
| inSel | input | 2 | Select code k, where x = 1 + 2^k; code 0 is rejected |
| statEn | input | 1 | Enables the generate/propagate/kill counts and the chain measurement |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Output beat consumed |
| outN | output | 128 | Odd result |
| outShift | output | 8 | Divisor exponent d |
| outGen | output | 8 | Generate count |
| outProp | output | 8 | Propagate count |
| outKill | output | 8 | Kill count |
| outChain | output | 8 | Longest carry chain |
| outOverflow | output | 1 | Sum exceeds 128 bits |
| outError | output | 1 | Input rejected |

## Verification
The bench uses the default build: two 64-bit words, for a 128-bit operand. With this width it can reach a carry crossing the word boundary (R8), overflow both from bits shifted out of the top and from the final carry-out, and an exact 2^128 sum at the overflow edge (R5). Operands of every length are drawn at random across all three multipliers, with statistics switched on and off (R4) and an output side that stalls at random (R7). A model in the bench predicts each beat from wide arithmetic and a bit-serial carry walk.

// File: rtl/collatz_pkg.sv
package collatz_pkg;
  // Strobes the control block sends to the datapath
  typedef struct packed {
    logic load;   // capture a new result into the output registers
  } ctrlStrobes_t;
endpackage

// File: rtl/collatz_ks_word.sv
module collatz_ks_word #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  localparam int STAGES = $clog2(WIDTH);

  logic [WIDTH-1:0] gLvl [0:STAGES];
  logic [WIDTH-1:0] pLvl [0:STAGES];
  logic [WIDTH-1:0] carries;

  assign gLvl[0] = addA & addB;
  assign pLvl[0] = addA ^ addB;

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    localparam int DIST = 1 << s;
    for (genvar i = 0; i < WIDTH; i++) begin : gBit
      if (i >= DIST) begin : gMerge
        assign gLvl[s+1][i] = gLvl[s][i] | (pLvl[s][i] & gLvl[s][i-DIST]);
        assign pLvl[s+1][i] = pLvl[s][i] & pLvl[s][i-DIST];
      end else begin : gPass
        assign gLvl[s+1][i] = gLvl[s][i];
        assign pLvl[s+1][i] = pLvl[s][i];
      end
    end
  end

  assign carries[0] = carryIn;
  for (genvar i = 1; i < WIDTH; i++) begin : gCarry
    assign carries[i] = gLvl[STAGES][i-1] | (pLvl[STAGES][i-1] & carryIn);
  end

  assign sum      = pLvl[0] ^ carries;
  assign carryOut = gLvl[STAGES][WIDTH-1] | (pLvl[STAGES][WIDTH-1] & carryIn);
endmodule

// File: rtl/collatz_ctrl.sv
module collatz_ctrl
  import collatz_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  assign inReady      = !outValid || outReady;
  assign strobes.load = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN)             outValid <= 1'b0;
    else if (strobes.load) outValid <= 1'b1;
    else if (outReady)     outValid <= 1'b0;
  end
endmodule

// File: rtl/collatz_datapath.sv
module collatz_datapath
  import collatz_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 2,
  parameter int DATA_W    = WORD_W * NUM_WORDS,
  parameter int CNT_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] inN,
  input  logic [1:0]        inSel,
  input  logic              statEn,
  output logic [DATA_W-1:0] resN,
  output logic [CNT_W-1:0]  resShift,
  output logic [CNT_W-1:0]  resGen,
  output logic [CNT_W-1:0]  resProp,
  output logic [CNT_W-1:0]  resKill,
  output logic [CNT_W-1:0]  resChain,
  output logic              resOverflow,
  output logic              resError
);
  logic [DATA_W-1:0] addB;
  logic [DATA_W-1:0] lostBits;
  logic [DATA_W-1:0] sumVec;
  logic [NUM_WORDS:0] wordCarry;
  logic badInput, overflow;
  logic [CNT_W-1:0] tzCount;
  logic [DATA_W-1:0] reduced;
  logic [CNT_W-1:0] genCnt, propCnt, killCnt, maxRun;

  // x = 1 + 2^k: addends are n and n << k, carry-in supplies the +1
  assign addB     = inN << inSel;
  assign lostBits = inN >> (DATA_W - int'(inSel));
  assign badInput = !inN[0] || (inSel == 2'd0);

  assign wordCarry[0] = 1'b1;
  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    collatz_ks_word #(.WIDTH(WORD_W)) i_word (
      .addA    (inN[w*WORD_W +: WORD_W]),
      .addB    (addB[w*WORD_W +: WORD_W]),
      .carryIn (wordCarry[w]),
      .sum     (sumVec[w*WORD_W +: WORD_W]),
      .carryOut(wordCarry[w+1])
    );
  end

  assign overflow = (lostBits != '0) || wordCarry[NUM_WORDS];

  // Lowest set bit of the sum gives d
  always_comb begin
    tzCount = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (sumVec[i]) tzCount = CNT_W'(i);
    end
  end

  assign reduced = sumVec >> tzCount;

  // Pair classification and carry-run measurement along the addends
  always_comb begin
    logic [CNT_W-1:0] run;
    logic bitG, bitP;
    genCnt  = '0;
    propCnt = '0;
    killCnt = '0;
    maxRun  = '0;
    run     = '0;
    for (int i = 0; i < DATA_W; i++) begin
      bitG = inN[i] & addB[i];
      bitP = inN[i] ^ addB[i];
      if (bitG)      genCnt  = genCnt + 1'b1;
      else if (bitP) propCnt = propCnt + 1'b1;
      else           killCnt = killCnt + 1'b1;
      // the carry entering position i is live when the previous run is open
      if (bitG)                                 run = CNT_W'(1);
      else if (bitP && (i == 0 || run != '0))   run = run + 1'b1;
      else                                      run = '0;
      if (run > maxRun) maxRun = run;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resN        <= '0;
      resShift    <= '0;
      resGen      <= '0;
      resProp     <= '0;
      resKill     <= '0;
      resChain    <= '0;
      resOverflow <= 1'b0;
      resError    <= 1'b0;
    end else if (strobes.load) begin
      resError    <= badInput;
      resOverflow <= !badInput && overflow;
      resN        <= (badInput || overflow) ? '0 : reduced;
      resShift    <= (badInput || overflow) ? '0 : tzCount;
      resGen      <= (!badInput && statEn) ? genCnt  : '0;
      resProp     <= (!badInput && statEn) ? propCnt : '0;
      resKill     <= (!badInput && statEn) ? killCnt : '0;
      resChain    <= (!badInput && statEn) ? maxRun  : '0;
    end
  end
endmodule

// File: rtl/collatz_step.sv
module collatz_step
  import collatz_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 2,
  localparam int DATA_W   = WORD_W * NUM_WORDS,
  localparam int CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inN,
  input  logic [1:0]        inSel,
  input  logic              statEn,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outN,
  output logic [CNT_W-1:0]  outShift,
  output logic [CNT_W-1:0]  outGen,
  output logic [CNT_W-1:0]  outProp,
  output logic [CNT_W-1:0]  outKill,
  output logic [CNT_W-1:0]  outChain,
  output logic              outOverflow,
  output logic              outError
);
  ctrlStrobes_t strobes;

  collatz_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobes (strobes)
  );

  collatz_datapath #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inN        (inN),
    .inSel      (inSel),
    .statEn     (statEn),
    .resN       (outN),
    .resShift   (outShift),
    .resGen     (outGen),
    .resProp    (outProp),
    .resKill    (outKill),
    .resChain   (outChain),
    .resOverflow(outOverflow),
    .resError   (outError)
  );
endmodule

// File: rtl/collatz_step_checker.sv
module collatz_step_checker #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outN,
  input logic [CNT_W-1:0]  outShift,
  input logic [CNT_W-1:0]  outGen,
  input logic [CNT_W-1:0]  outProp,
  input logic [CNT_W-1:0]  outKill,
  input logic [CNT_W-1:0]  outChain,
  input logic              outOverflow,
  input logic              outError
);
  logic [CNT_W+1:0] pairTotal;
  assign pairTotal = {2'b00, outGen} + {2'b00, outProp} + {2'b00, outKill};

  a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outN) && $stable(outShift) && $stable(outChain));

  a_r1_result_odd: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outError && !outOverflow |-> outN[0]);

  a_r2_pair_total: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outError |-> (pairTotal == (CNT_W+2)'(DATA_W)) || (pairTotal == '0));

  a_r3_chain_bound: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outChain <= CNT_W'(DATA_W));

  a_r5_overflow_clears: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outOverflow |-> outN == '0 && outShift == '0);

  a_r6_error_clean: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outError |-> outN == '0 && !outOverflow && pairTotal == '0 && outChain == '0);
endmodule

bind collatz_step collatz_step_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .inReady    (inReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outN       (outN),
  .outShift   (outShift),
  .outGen     (outGen),
  .outProp    (outProp),
  .outKill    (outKill),
  .outChain   (outChain),
  .outOverflow(outOverflow),
  .outError   (outError)
);

// File: tb/test_collatz_step.sv
module test_collatz_step;
  localparam int CLK_PERIOD = 10;
  localparam int W = 128;

  typedef struct {
    logic [W-1:0] n;
    logic [7:0]   shift, gen, prop, kill, chain;
    logic         ovf, err, st;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [W-1:0] inN = '0;
  logic [1:0] inSel = '0;
  logic statEn = 1'b0;
  logic outValid, outReady = 1'b1;
  logic [W-1:0] outN;
  logic [7:0] outShift, outGen, outProp, outKill, outChain;
  logic outOverflow, outError;

  int checks = 0;
  int errors = 0;
  item_t expQ[$];
  bit randReady = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  collatz_step i_collatz_step (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inN(inN), .inSel(inSel), .statEn(statEn),
    .outValid(outValid), .outReady(outReady), .outN(outN), .outShift(outShift),
    .outGen(outGen), .outProp(outProp), .outKill(outKill), .outChain(outChain),
    .outOverflow(outOverflow), .outError(outError)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected beat from wide arithmetic and a bit-serial carry walk
  function automatic item_t model(input logic [W-1:0] n, input logic [1:0] sel, input logic st);
    item_t it;
    logic [W+7:0] wide;
    logic [W-1:0] b;
    int run, best;
    logic carry;
    it.n = '0; it.shift = '0; it.gen = '0; it.prop = '0; it.kill = '0; it.chain = '0;
    it.ovf = 1'b0; it.err = 1'b0; it.st = st;
    if (!n[0] || sel == 2'd0) begin
      it.err = 1'b1;
      return it;
    end
    wide = {8'd0, n} * (W+8)'((1 << sel) + 1) + (W+8)'(1);
    if (wide[W+7:W] != 0) it.ovf = 1'b1;
    else begin
      it.n = wide[W-1:0];
      while (!it.n[0]) begin
        it.n = it.n >> 1;
        it.shift++;
      end
    end
    if (st) begin
      b = n << sel;
      carry = 1'b1; run = 0; best = 0;
      for (int i = 0; i < W; i++) begin
        if (n[i] & b[i]) begin it.gen++; run = 1; carry = 1'b1; end
        else if (n[i] ^ b[i]) begin
          it.prop++;
          if (carry) run++; else run = 0;
        end else begin it.kill++; run = 0; carry = 1'b0; end
        if (run > best) best = run;
      end
      it.chain = 8'(best);
    end
    return it;
  endfunction

  task automatic send(input logic [W-1:0] n, input logic [1:0] sel, input logic st);
    expQ.push_back(model(n, sel, st));
    inN = n; inSel = sel; statEn = st; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Output-side ready changes just after each rising edge
  always @(posedge clk) begin
    #1;
    outReady <= randReady ? ($urandom % 4 != 0) : 1'b1;
  end

  // Monitor: stall stability and scoreboard compare
  logic prevStall = 1'b0;
  logic [W-1:0] prevN = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        check(outValid === 1'b1 && outN === prevN, "R7 stall hold", outN, prevN);
      end
      prevStall = outValid && !outReady;
      prevN = outN;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected beat", outN, '0);
        end else begin
          item_t e;
          e = expQ.pop_front();
          check(outError === e.err, "R6 error flag", W'(outError), W'(e.err));
          check(outOverflow === e.ovf, "R5 overflow flag", W'(outOverflow), W'(e.ovf));
          check(outN === e.n, e.ovf ? "R5 result cleared" : "R1/R8 result", outN, e.n);
          check(outShift === e.shift, "R1 shift", W'(outShift), W'(e.shift));
          check(outGen === e.gen && outProp === e.prop && outKill === e.kill,
                e.st ? "R2 pair counts" : "R4 counts off",
                {outGen, outProp, outKill}, {e.gen, e.prop, e.kill});
          check(outChain === e.chain, e.st ? "R3 chain" : "R4 chain off", W'(outChain), W'(e.chain));
        end
      end
    end
  end

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [W-1:0] third;
    third = {64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R7 reset outValid", W'(outValid), '0);
    check(inReady === 1'b1, "R7 reset inReady", W'(inReady), 1);
    check(outN === '0, "R1 reset outN", outN, '0);

    // R7: result visible right after the accepting edge
    send(W'(1), 2'd1, 1'b1);
    check(outValid === 1'b1, "R7 one-cycle latency", W'(outValid), 1);

    // R1 directed cases for each multiplier
    send(W'(7), 2'd2, 1'b1);
    send(W'(27), 2'd1, 1'b1);
    send(W'(1), 2'd3, 1'b1);
    // R8: carry crosses from the low word into the high word
    send({64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 2'd1, 1'b1);
    send({64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 2'd3, 1'b1);
    // R5: exact 2^128 overflows, one step below fits
    send(third, 2'd1, 1'b1);
    send(third - 2, 2'd1, 1'b1);
    send({1'b1, 126'd0, 1'b1}, 2'd1, 1'b1);
    send({3'b001, 124'd0, 1'b1}, 2'd3, 1'b0);
    // R6: rejected inputs
    send(W'(6), 2'd1, 1'b1);
    send(W'(9), 2'd0, 1'b1);
    // R4: same operand with statistics off
    send(W'(27), 2'd1, 1'b0);

    // Random operands of many lengths under output back-pressure
    randReady = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] r;
      r = {$urandom, $urandom, $urandom, $urandom};
      r = r >> ($urandom % W);
      if ($urandom % 16 != 0) r[0] = 1'b1;
      send(r, 2'($urandom % 4), 1'($urandom % 3 != 0));
      if ($urandom % 4 == 0) @(negedge clk);
    end
    randReady = 1'b0;
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R7 all beats delivered", W'(expQ.size()), '0);
    finishRun();
  end
endmodule